// File: doc/BRIEF.md
# Nibble-Mode Character Display Controller

This block takes single bytes from a host, each tagged with a 2-bit target mode, and writes them to a character display over a 4-bit data bus. The display side has four bidirectional data lines, brought out as separate output, input and output-enable signals. It also has two mode-select lines, an enable strobe and a read/write line.

Before each byte the block polls the display. A poll is two back-to-back nibble reads with the data lines turned to inputs. The block keeps polling while the busy flag in the first nibble is set. It then turns the bus back to outputs and sends the byte as two nibble writes, high nibble first.

Setup, enable-high and hold times are parameters counted in clock cycles. The host sees a valid/ready handshake. Ready stays low from acceptance until the last write strobe and its hold time have finished.

Top module: `lcd_nib_ctrl`

## Requirements
- R1: During nibble writes `lcd_ms` carries the mode of the current request. The encodings are 2'b00 command, 2'b01 display address, 2'b10 data and 2'b11 cursor address, and `lcd_ms[1]` is the upper line.
- R2: For every strobe, `lcd_d_o`, `lcd_d_oe`, `lcd_ms` and `lcd_rw` are stable for at least `T_SU` cycles before `lcd_en` rises. They stay unchanged while it is high and for the cycle in which it falls.
- R3: Every enable pulse is high for exactly `T_EH` consecutive cycles.
- R4: An accepted byte produces exactly two write strobes (`lcd_rw` = 0). The first carries bits 7:4 and the second carries bits 3:0.
- R5: While idle, `lcd_ms` shows the mode register. That register is 2'b00 after reset and keeps the last accepted mode until the next request.
- R6: Each poll is two enable pulses with `lcd_rw` = 1, `lcd_d_oe` = 0 and `lcd_ms` = 2'b00, and it comes before any write of the byte.
- R7: Busy is bit 3 of the first nibble of a poll. The block polls again while it is 1, and bit 3 of the second nibble has no effect.
- R8: After every poll, in the cycle where `lcd_rw` falls, `lcd_d_oe` = 1 and `lcd_d_o` = 4'h0.
- R9: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until both write strobes and their hold time have finished.
- R10: After reset `req_ready` = 1, `lcd_en` = 0, `lcd_rw` = 0, `lcd_d_oe` = 1, `lcd_d_o` = 4'h0 and `lcd_ms` = 2'b00.
- R11: A clear command (byte 8'h01, mode 2'b00) goes out as nibble 4'h0 and then nibble 4'h1, both with `lcd_ms` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a byte |
| req_ready | output | 1 | Block can accept a byte |
| req_byte | input | 8 | Byte to send |
| req_mode | input | 2 | Target mode for the byte |
| lcd_d_o | output | 4 | Data lines, driven value |
| lcd_d_i | input | 4 | Data lines, sampled value |
| lcd_d_oe | output | 1 | Data line output enable |
| lcd_ms | output | 2 | Mode-select lines |
| lcd_en | output | 1 | Enable strobe |
| lcd_rw | output | 1 | Read (1) / write (0) |

## Verification
The assertions assume that the setup, enable-high and hold parameters are each at least one cycle. They also assume the display drives `lcd_d_i` only as a function of the bus state, never of `req_*`. The bench's display model changes its status nibble only on the falling clock edge that follows a read strobe's fall, so the value is steady for the whole enable-high window in which the block samples. Host requests are offered only while `req_ready` is high and are withdrawn in the cycle after acceptance, so every handshake the assertions see is a clean single transfer.

// File: rtl/lcd_nib_pkg.sv
package lcd_nib_pkg;
  // Controller phase; each read or write nibble walks setup -> enable high -> hold.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_SU  = 3'd1,
    ST_RD_EH  = 3'd2,
    ST_RD_HLD = 3'd3,
    ST_TURN   = 3'd4,
    ST_WR_SU  = 3'd5,
    ST_WR_EH  = 3'd6,
    ST_WR_HLD = 3'd7
  } lcd_st_e;

  // Mode-select encodings, upper line is bit 1.
  localparam logic [1:0] MS_CMD   = 2'b00;
  localparam logic [1:0] MS_DADDR = 2'b01;
  localparam logic [1:0] MS_DATA  = 2'b10;
  localparam logic [1:0] MS_CADDR = 2'b11;

  localparam int BUSY_BIT = 3;
endpackage

// File: rtl/lcd_nib_timer.sv
module lcd_nib_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  // Loaded with len-1 on phase entry, so a phase lasts len cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= len - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/lcd_nib_pins.sv
module lcd_nib_pins
  import lcd_nib_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lcd_st_e    st_nxt,
  input  logic [3:0] nib_nxt,
  input  logic [1:0] mode_nxt,
  output logic       ready,
  output logic [3:0] d_o,
  output logic       d_oe,
  output logic [1:0] ms,
  output logic       en,
  output logic       rw
);
  // Pins are registered from the next phase, so they line up with the phase register.
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      d_o   <= 4'h0;
      d_oe  <= 1'b1;
      ms    <= MS_CMD;
      en    <= 1'b0;
      rw    <= 1'b0;
    end else begin
      ready <= (st_nxt == ST_IDLE);
      case (st_nxt)
        ST_RD_SU, ST_RD_EH, ST_RD_HLD: begin
          d_o  <= 4'h0;
          d_oe <= 1'b0;
          ms   <= MS_CMD;
          en   <= (st_nxt == ST_RD_EH);
          rw   <= 1'b1;
        end
        ST_WR_SU, ST_WR_EH, ST_WR_HLD: begin
          d_o  <= nib_nxt;
          d_oe <= 1'b1;
          ms   <= mode_nxt;
          en   <= (st_nxt == ST_WR_EH);
          rw   <= 1'b0;
        end
        ST_TURN: begin
          d_o  <= 4'h0;
          d_oe <= 1'b1;
          ms   <= MS_CMD;
          en   <= 1'b0;
          rw   <= 1'b0;
        end
        default: begin
          d_o  <= 4'h0;
          d_oe <= 1'b1;
          ms   <= mode_nxt;
          en   <= 1'b0;
          rw   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_nib_ctrl.sv
module lcd_nib_ctrl
  import lcd_nib_pkg::*;
#(
  parameter int T_SU  = 2,
  parameter int T_EH  = 4,
  parameter int T_HLD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_byte,
  input  logic [1:0] req_mode,
  output logic [3:0] lcd_d_o,
  input  logic [3:0] lcd_d_i,
  output logic       lcd_d_oe,
  output logic [1:0] lcd_ms,
  output logic       lcd_en,
  output logic       lcd_rw
);
  localparam int T_MAX = (T_SU > T_EH) ? ((T_SU > T_HLD) ? T_SU : T_HLD)
                                       : ((T_EH > T_HLD) ? T_EH : T_HLD);
  localparam int CW = $clog2(T_MAX + 1);

  lcd_st_e     st_q, st_d;
  logic [7:0]  byte_q, byte_d;
  logic [1:0]  mode_q, mode_d;
  logic        rd2_q, rd2_d;
  logic        wrlo_q, wrlo_d;
  logic        busy_q, busy_d;
  logic        tmr_start, tmr_last;
  logic [CW-1:0] tmr_len;
  logic [3:0]  nib_nxt;
  logic        unused_rd;

  assign unused_rd = ^lcd_d_i[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      byte_q <= 8'h00;
      mode_q <= MS_CMD;
      rd2_q  <= 1'b0;
      wrlo_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      byte_q <= byte_d;
      mode_q <= mode_d;
      rd2_q  <= rd2_d;
      wrlo_q <= wrlo_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    st_d   = st_q;
    byte_d = byte_q;
    mode_d = mode_q;
    rd2_d  = rd2_q;
    wrlo_d = wrlo_q;
    busy_d = busy_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          byte_d = req_byte;
          mode_d = req_mode;
          rd2_d  = 1'b0;
          st_d   = ST_RD_SU;
        end
      end
      ST_RD_SU:  if (tmr_last) st_d = ST_RD_EH;
      ST_RD_EH: begin
        if (tmr_last) begin
          st_d = ST_RD_HLD;
          if (!rd2_q) busy_d = lcd_d_i[BUSY_BIT];
        end
      end
      ST_RD_HLD: begin
        if (tmr_last) begin
          if (!rd2_q) begin
            rd2_d = 1'b1;
            st_d  = ST_RD_SU;
          end else begin
            st_d = ST_TURN;
          end
        end
      end
      ST_TURN: begin
        if (busy_q) begin
          rd2_d = 1'b0;
          st_d  = ST_RD_SU;
        end else begin
          wrlo_d = 1'b0;
          st_d   = ST_WR_SU;
        end
      end
      ST_WR_SU:  if (tmr_last) st_d = ST_WR_EH;
      ST_WR_EH:  if (tmr_last) st_d = ST_WR_HLD;
      ST_WR_HLD: begin
        if (tmr_last) begin
          if (!wrlo_q) begin
            wrlo_d = 1'b1;
            st_d   = ST_WR_SU;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Phase length chosen by the phase being entered.
  always_comb begin
    case (st_d)
      ST_RD_SU, ST_WR_SU:   tmr_len = CW'(T_SU);
      ST_RD_EH, ST_WR_EH:   tmr_len = CW'(T_EH);
      ST_RD_HLD, ST_WR_HLD: tmr_len = CW'(T_HLD);
      default:              tmr_len = CW'(1);
    endcase
  end

  assign tmr_start = (st_d != st_q);
  assign nib_nxt   = wrlo_d ? byte_d[3:0] : byte_d[7:4];

  lcd_nib_timer #(.CW(CW)) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  lcd_nib_pins pins_i (
    .clk      (clk),
    .rst      (rst),
    .st_nxt   (st_d),
    .nib_nxt  (nib_nxt),
    .mode_nxt (mode_d),
    .ready    (req_ready),
    .d_o      (lcd_d_o),
    .d_oe     (lcd_d_oe),
    .ms       (lcd_ms),
    .en       (lcd_en),
    .rw       (lcd_rw)
  );
endmodule

// File: rtl/lcd_nib_ctrl_chk.sv
module lcd_nib_ctrl_chk #(
  parameter int T_EH = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] lcd_d_o,
  input logic       lcd_d_oe,
  input logic [1:0] lcd_ms,
  input logic       lcd_en,
  input logic       lcd_rw
);
  logic [15:0] en_run;

  always_ff @(posedge clk) begin
    if (rst) en_run <= 16'd0;
    else     en_run <= lcd_en ? en_run + 16'd1 : 16'd0;
  end

  assert_en_width_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> en_run == 16'(T_EH));

  assert_bus_steady_R2: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> $stable(lcd_d_o) && $stable(lcd_ms) && $stable(lcd_rw) && $stable(lcd_d_oe));

  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> $stable(lcd_d_o) && $stable(lcd_ms) && $stable(lcd_rw));

  assert_read_dir_R6: assert property (@(posedge clk) disable iff (rst)
    lcd_rw |-> !lcd_d_oe && lcd_ms == 2'b00);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_rw) |-> lcd_d_oe && lcd_d_o == 4'h0);

  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
endmodule

bind lcd_nib_ctrl lcd_nib_ctrl_chk #(.T_EH(T_EH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .lcd_d_o   (lcd_d_o),
  .lcd_d_oe  (lcd_d_oe),
  .lcd_ms    (lcd_ms),
  .lcd_en    (lcd_en),
  .lcd_rw    (lcd_rw)
);

// File: tb/lcd_nib_ctrl_tb_top.sv
module lcd_nib_ctrl_tb_top;
  localparam int T_SU  = 2;
  localparam int T_EH  = 3;
  localparam int T_HLD = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_byte = 8'h00;
  logic [1:0] req_mode = 2'b00;
  logic [3:0] lcd_d_o;
  logic [3:0] lcd_d_i;
  logic       lcd_d_oe;
  logic [1:0] lcd_ms;
  logic       lcd_en;
  logic       lcd_rw;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lcd_nib_ctrl #(.T_SU(T_SU), .T_EH(T_EH), .T_HLD(T_HLD)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_byte(req_byte), .req_mode(req_mode), .lcd_d_o(lcd_d_o), .lcd_d_i(lcd_d_i),
    .lcd_d_oe(lcd_d_oe), .lcd_ms(lcd_ms), .lcd_en(lcd_en), .lcd_rw(lcd_rw)
  );

  // Display model and bus monitor, all sampled on the falling edge.
  int   busy_left = 0;
  bit   rd_phase  = 1'b0;
  logic [3:0] wnib [64];
  logic [1:0] wms  [64];
  int   wn = 0, rd_n = 0, turn_n = 0;
  int   setup_err = 0, width_err = 0, hold_err = 0, rdms_err = 0, turn_err = 0;
  logic prev_en = 1'b0, prev_rw = 1'b0, prev_oe = 1'b1;
  logic [3:0] prev_d = 4'h0;
  logic [1:0] prev_ms = 2'b00;
  int   stab = 0, hi_cnt = 0;

  // First nibble carries busy in bit 3; the second always has bit 3 set (R7: must be ignored).
  assign lcd_d_i = rd_phase ? 4'b1010 : {busy_left != 0, 3'b011};

  always @(negedge clk) begin
    if (!rst) begin
      if (lcd_d_o == prev_d && lcd_ms == prev_ms && lcd_rw == prev_rw && lcd_d_oe == prev_oe)
        stab = stab + 1;
      else
        stab = 1;
      if (lcd_en && !prev_en) begin
        if (stab < T_SU + 1) setup_err++;
        hi_cnt = 1;
        if (lcd_rw) begin
          rd_n++;
          if (lcd_ms != 2'b00 || lcd_d_oe) rdms_err++;
        end else begin
          wnib[wn % 64] = lcd_d_o;
          wms[wn % 64]  = lcd_ms;
          wn++;
        end
      end else if (lcd_en) begin
        hi_cnt++;
        if (stab < hi_cnt) hold_err++;
      end else if (prev_en) begin
        if (hi_cnt != T_EH) width_err++;
        if (lcd_d_o != prev_d || lcd_ms != prev_ms || lcd_rw != prev_rw) hold_err++;
        if (lcd_rw) begin
          if (!rd_phase && busy_left > 0) busy_left--;
          rd_phase = ~rd_phase;
        end
      end
      if (prev_rw && !lcd_rw) begin
        turn_n++;
        if (!lcd_d_oe || lcd_d_o != 4'h0) turn_err++;
      end
    end
    prev_en = lcd_en; prev_rw = lcd_rw; prev_oe = lcd_d_oe;
    prev_d  = lcd_d_o; prev_ms = lcd_ms;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(lcd_en == 1'b0, "R10 en after reset", int'(lcd_en), 0);
    chk(lcd_rw == 1'b0, "R10 rw after reset", int'(lcd_rw), 0);
    chk(lcd_d_oe == 1'b1, "R10 oe after reset", int'(lcd_d_oe), 1);
    chk(lcd_d_o == 4'h0, "R10 data after reset", int'(lcd_d_o), 0);
    chk(lcd_ms == 2'b00, "R10/R5 mode after reset", int'(lcd_ms), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(lcd_en == 1'b0 && req_ready, "R10 idle after release", int'(lcd_en), 0);
  endtask

  task automatic t_send(input logic [7:0] b, input logic [1:0] m, input int busy, input string tag);
    int wb, rb, tb, eb;
    wb = wn; rb = rd_n; tb = turn_n;
    eb = setup_err + hold_err;
    busy_left = busy;
    rd_phase  = 1'b0;
    req_byte  = b; req_mode = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_byte  = ~b; req_mode = ~m;
    chk(req_ready == 1'b0, {tag, " R9 ready low after accept"}, int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    chk(wn - wb == 2, {tag, " R4/R9 two strobes done when ready returns"}, wn - wb, 2);
    chk(wnib[wb % 64] == b[7:4], {tag, " R4 high nibble first"}, int'(wnib[wb % 64]), int'(b[7:4]));
    chk(wnib[(wb + 1) % 64] == b[3:0], {tag, " R4 low nibble second"}, int'(wnib[(wb + 1) % 64]), int'(b[3:0]));
    chk(wms[wb % 64] == m, {tag, " R1 mode on high nibble"}, int'(wms[wb % 64]), int'(m));
    chk(wms[(wb + 1) % 64] == m, {tag, " R1 mode on low nibble"}, int'(wms[(wb + 1) % 64]), int'(m));
    chk(rd_n - rb == 2 * (busy + 1), {tag, " R6/R7 read strobes"}, rd_n - rb, 2 * (busy + 1));
    chk(turn_n - tb == busy + 1, {tag, " R8 turnarounds"}, turn_n - tb, busy + 1);
    chk(setup_err + hold_err == eb, {tag, " R2 setup/hold violations"}, setup_err + hold_err - eb, 0);
    chk(width_err == 0, {tag, " R3 enable width errors"}, width_err, 0);
    chk(rdms_err == 0, {tag, " R6 read bus state errors"}, rdms_err, 0);
    chk(turn_err == 0, {tag, " R8 turnaround bus errors"}, turn_err, 0);
    repeat (3) @(negedge clk);
    chk(lcd_ms == m, {tag, " R5 mode persists in idle"}, int'(lcd_ms), int'(m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_send(8'h01, 2'b00, 0, "R11 clear command");
    t_send(8'hA5, 2'b10, 2, "data busy twice");
    t_send(8'h3C, 2'b01, 0, "display address");
    t_send(8'h7E, 2'b11, 1, "cursor address busy once");
    t_send(8'hF0, 2'b10, 3, "data busy thrice");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule